// File: doc/BRIEF.md
# Luma-to-4:2:2 Byte Stream Formatter

The block turns a stream of 8-bit luma samples from a monochrome source into a multiplexed 4:2:2 byte stream, one byte per pixel-clock cycle. Each input sample becomes one luma byte. The block places a fixed neutral chroma byte next to each luma byte, so a group of four output bytes carries two luma samples and one blue-difference and one red-difference chroma byte. The block also drives an output data clock that runs at the pixel-clock rate. A downstream receiver uses this clock to capture the bytes.

An 8-bit control byte drives the block directly on a plain input pin. Bit 7 turns the output on or off. Bit 6 picks the luma code range. Bits 5:4 pick the interleave order. Bit 3 picks the clock edge that launches the data. Bits 2:0 are fixed at 1 and have no function. The block does not read the control byte on every cycle. It samples the byte only when a four-byte group starts, so a group is never split across two settings.

The input side is a valid/ready stream. The output side has a valid strobe and no ready, because it drives a capture bus that cannot stall. The input raises `in_ready` only when the block is enabled and the current byte slot is a luma slot. `in_ready` does not depend on `in_valid`. A sample is taken on a clock edge where both are high. Chroma slots are emitted without waiting for input. If a luma slot has no valid sample, the block emits an idle cycle and keeps its place in the group.

Top module: `ycc_byte_fmt`

## Requirements
- R1: With control bit 7 at 0, `out_valid` is low, `out_data` is 0x00, `in_ready` is low and `out_dclk` is held low.
- R2: While `rst_n` is low, the control setting is 0x47, so the output is off, and the next group starts at slot 0.
- R3: With bit 6 at 0, each emitted luma byte is the input sample clamped to the range 16..235.
- R4: With bit 6 at 1, each emitted luma byte is the input sample clamped to the range 1..254.
- R5: Bits 5:4 set the order of the four slots in a group. Code 0 gives Cb,Y,Cr,Y. Code 1 gives Y,Cb,Y,Cr. Code 2 gives Cr,Y,Cb,Y. Code 3 gives Y,Cr,Y,Cb.
- R6: A Cb slot emits `CB_FILL` and a Cr slot emits `CR_FILL`. Both default to 0x80, which lies inside both ranges and is never clamped.
- R7: While the output is enabled, bit 3 at 0 makes `out_dclk` follow `clk`, so data changes on its rising edge. Bit 3 at 1 makes `out_dclk` the inverse of `clk`, so data changes on its falling edge.
- R8: The control byte is taken only at slot 0 of a group. A change made during slots 1..3 has no effect until the next group begins.
- R9: Each emitted byte appears on `out_data`, with `out_valid` high, on the clock edge at which its slot is served. A luma slot is served only on an edge where `in_valid` and `in_ready` are both high. If a luma slot has no valid sample, the block gives one cycle with `out_valid` low and `out_data` at 0x00, and it stays in that slot.
- R10: Control bits 2:0 have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctrl | input | 8 | Control byte: enable, range, order, clock phase |
| in_valid | input | 1 | A luma sample is present |
| in_ready | output | 1 | The block takes a sample on this edge |
| in_luma | input | 8 | Luma sample |
| out_valid | output | 1 | `out_data` carries a byte this cycle |
| out_data | output | 8 | Multiplexed 4:2:2 byte |
| out_dclk | output | 1 | Output data clock, with the selected polarity or held low |

## Verification
The bench changes the control byte at random in the middle of groups. A design that samples the control byte on every cycle would then change the interleave order or the range partway through a group. The bench drives luma values right at each range edge and one code beyond it. An off-by-one or swapped bound would pass 15, 236, 0 or 255 through unchanged. The chroma fill values are set to different numbers, so if Cb and Cr were swapped, or if the chroma came first when the luma should, the mismatch shows up on the first group. The bench holds back input during luma slots to find a design that skips the slot or emits a stale byte. It samples `out_dclk` in both clock phases, which exposes an inverted polarity and a clock that keeps running while the output is off.

// File: rtl/ycc_fmt_pkg.sv
package ycc_fmt_pkg;

  typedef struct packed {
    logic       en;
    logic       full_rng;
    logic [1:0] order;
    logic       inv_clk;
    logic [2:0] rsvd;
  } ycc_cfg_t;

  typedef enum logic [1:0] {
    COMP_Y  = 2'd0,
    COMP_CB = 2'd1,
    COMP_CR = 2'd2
  } comp_e;

  localparam logic [7:0] CFG_RESET   = 8'h47;
  localparam logic [2:0] RSVD_VALUE  = 3'b111;
  localparam int         GROUP_BYTES = 4;
  localparam int         SLOT_W      = $clog2(GROUP_BYTES);

endpackage

// File: rtl/ycc_cfg_gate.sv
module ycc_cfg_gate
  import ycc_fmt_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic [7:0] ctrl_i,
  input  logic     at_boundary_i,
  output ycc_cfg_t eff_o,
  output ycc_cfg_t held_o
);

  ycc_cfg_t ctrl_cfg;
  ycc_cfg_t held_q;

  always_comb begin
    ctrl_cfg      = ycc_cfg_t'(ctrl_i | {5'b0, RSVD_VALUE});
    ctrl_cfg.rsvd = RSVD_VALUE;
  end

  assign eff_o  = at_boundary_i ? ctrl_cfg : held_q;
  assign held_o = held_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) held_q <= ycc_cfg_t'(CFG_RESET);
    else        held_q <= eff_o;
  end

  assert_cfg_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(at_boundary_i) |-> $stable(held_q));

  assert_rsvd_fixed_R10: assert property (@(posedge clk) disable iff (!rst_n)
    held_q.rsvd == RSVD_VALUE);

endmodule

// File: rtl/ycc_slot_seq.sv
module ycc_slot_seq
  import ycc_fmt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              luma_first_i,
  input  logic              cr_first_i,
  input  logic              advance_i,
  output logic [SLOT_W-1:0] slot_o,
  output logic              at_boundary_o,
  output comp_e             comp_o
);

  logic [SLOT_W-1:0] slot_q;
  logic              is_luma;
  logic              pick_cr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         slot_q <= '0;
    else if (advance_i) slot_q <= slot_q + 1'b1;
  end

  // even slots carry luma when luma leads, odd slots otherwise
  assign is_luma = slot_q[0] ^ luma_first_i;
  // the second half of the group swaps the chroma component
  assign pick_cr = cr_first_i ^ slot_q[SLOT_W-1];

  always_comb begin
    if (is_luma)      comp_o = COMP_Y;
    else if (pick_cr) comp_o = COMP_CR;
    else              comp_o = COMP_CB;
  end

  assign slot_o        = slot_q;
  assign at_boundary_o = (slot_q == '0);

  assert_slot_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
    advance_i |=> slot_q == SLOT_W'($past(slot_q) + 1'b1));

  assert_slot_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !advance_i |=> $stable(slot_q));

endmodule

// File: rtl/ycc_range_clamp.sv
module ycc_range_clamp #(
  parameter int DW      = 8,
  parameter int LIM_LO  = 16,
  parameter int LIM_HI  = 235,
  parameter int FULL_LO = 1,
  parameter int FULL_HI = 254
) (
  input  logic [DW-1:0] y_i,
  input  logic          full_i,
  output logic [DW-1:0] y_o
);

  logic [DW-1:0] lo;
  logic [DW-1:0] hi;

  assign lo = full_i ? DW'(FULL_LO) : DW'(LIM_LO);
  assign hi = full_i ? DW'(FULL_HI) : DW'(LIM_HI);

  always_comb begin
    if (y_i < lo)      y_o = lo;
    else if (y_i > hi) y_o = hi;
    else               y_o = y_i;
  end

  always_comb begin
    if (!$isunknown({y_i, full_i})) begin
      assert_clamp_bounds_R3: assert (y_o >= (full_i ? DW'(FULL_LO) : DW'(LIM_LO)) &&
                                      y_o <= (full_i ? DW'(FULL_HI) : DW'(LIM_HI)));
    end
  end

endmodule

// File: rtl/ycc_dclk_drive.sv
module ycc_dclk_drive (
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  input  logic inv_i,
  output logic dclk_o
);

  assign dclk_o = en_i & (clk ^ inv_i);

  assert_dclk_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |-> !dclk_o);

endmodule

// File: rtl/ycc_byte_fmt.sv
module ycc_byte_fmt
  import ycc_fmt_pkg::*;
#(
  parameter int         DW      = 8,
  parameter logic [7:0] CB_FILL = 8'h80,
  parameter logic [7:0] CR_FILL = 8'h80,
  parameter int         LIM_LO  = 16,
  parameter int         LIM_HI  = 235,
  parameter int         FULL_LO = 1,
  parameter int         FULL_HI = 254
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [7:0]    ctrl,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [DW-1:0] in_luma,
  output logic          out_valid,
  output logic [DW-1:0] out_data,
  output logic          out_dclk
);

  ycc_cfg_t          eff_cfg;
  ycc_cfg_t          held_cfg;
  logic [SLOT_W-1:0] slot;
  logic              at_boundary;
  comp_e             comp;
  logic              advance;
  logic [DW-1:0]     luma_clamped;
  logic [DW-1:0]     byte_d;
  logic              out_valid_q;
  logic [DW-1:0]     out_data_q;

  ycc_cfg_gate u_cfg (
    .clk           (clk),
    .rst_n         (rst_n),
    .ctrl_i        (ctrl),
    .at_boundary_i (at_boundary),
    .eff_o         (eff_cfg),
    .held_o        (held_cfg)
  );

  ycc_slot_seq u_seq (
    .clk           (clk),
    .rst_n         (rst_n),
    .luma_first_i  (eff_cfg.order[0]),
    .cr_first_i    (eff_cfg.order[1]),
    .advance_i     (advance),
    .slot_o        (slot),
    .at_boundary_o (at_boundary),
    .comp_o        (comp)
  );

  ycc_range_clamp #(
    .DW      (DW),
    .LIM_LO  (LIM_LO),
    .LIM_HI  (LIM_HI),
    .FULL_LO (FULL_LO),
    .FULL_HI (FULL_HI)
  ) u_clamp (
    .y_i    (in_luma),
    .full_i (eff_cfg.full_rng),
    .y_o    (luma_clamped)
  );

  ycc_dclk_drive u_dclk (
    .clk    (clk),
    .rst_n  (rst_n),
    .en_i   (held_cfg.en),
    .inv_i  (held_cfg.inv_clk),
    .dclk_o (out_dclk)
  );

  assign in_ready = eff_cfg.en && (comp == COMP_Y);
  assign advance  = eff_cfg.en && ((comp != COMP_Y) || in_valid);

  always_comb begin
    case (comp)
      COMP_CB: byte_d = DW'(CB_FILL);
      COMP_CR: byte_d = DW'(CR_FILL);
      default: byte_d = luma_clamped;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid_q <= 1'b0;
      out_data_q  <= '0;
    end else begin
      out_valid_q <= advance;
      out_data_q  <= advance ? byte_d : '0;
    end
  end

  assign out_valid = out_valid_q;
  assign out_data  = out_data_q;

  assert_valid_needs_en_R1: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> held_cfg.en);

  assert_idle_is_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> out_data == '0);

  assert_take_emits_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid);

  assert_chroma_fill_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && comp != COMP_Y) |=>
      (out_data == DW'(CB_FILL) || out_data == DW'(CR_FILL)));

endmodule

// File: tb/sim_ycc_byte_fmt.sv
module sim_ycc_byte_fmt;

  localparam logic [7:0] CB_V = 8'h7E;
  localparam logic [7:0] CR_V = 8'h82;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] ctrl = 8'h47;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic [7:0] in_luma = 8'h00;
  logic       out_valid;
  logic [7:0] out_data;
  logic       out_dclk;

  int errors = 0;
  int checks = 0;
  int cycles = 0;

  always #2 clk = ~clk;

  ycc_byte_fmt #(.CB_FILL(CB_V), .CR_FILL(CR_V)) u0 (
    .clk(clk), .rst_n(rst_n), .ctrl(ctrl), .in_valid(in_valid),
    .in_ready(in_ready), .in_luma(in_luma), .out_valid(out_valid),
    .out_data(out_data), .out_dclk(out_dclk)
  );

  // reference model state
  int         m_slot = 0;
  logic [7:0] m_cfg = 8'h47;
  logic       e_valid = 1'b0;
  logic [7:0] e_data = 8'h00;
  string      tag = "R2";

  function automatic logic [7:0] clampv(input logic [7:0] y, input logic full);
    int lo = full ? 1 : 16;
    int hi = full ? 254 : 235;
    if (int'(y) < lo) return 8'(lo);
    if (int'(y) > hi) return 8'(hi);
    return y;
  endfunction

  function automatic bit luma_slot(input logic [7:0] c, input int s);
    return c[4] ? (s % 2 == 0) : (s % 2 == 1);
  endfunction

  task automatic check(input string t, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h at %0t", t, what, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (!rst_n) begin
      m_slot = 0; m_cfg = 8'h47; e_valid = 0; e_data = 0; tag = "R2";
    end else begin
      bit deferred;
      deferred = (m_slot != 0) && (ctrl[7:3] != m_cfg[7:3]);
      if (m_slot == 0) m_cfg = ctrl;
      if (!m_cfg[7]) begin
        e_valid = 0; e_data = 0; tag = "R1";
      end else if (luma_slot(m_cfg, m_slot)) begin
        if (in_valid) begin
          e_valid = 1; e_data = clampv(in_luma, m_cfg[6]);
          m_slot = (m_slot + 1) % 4;
          tag = m_cfg[6] ? "R5/R4" : "R5/R3";
        end else begin
          e_valid = 0; e_data = 0; tag = "R9";
        end
      end else begin
        bit cr;
        cr = m_cfg[5] ^ (m_slot >= 2);
        e_valid = 1; e_data = cr ? CR_V : CB_V;
        m_slot = (m_slot + 1) % 4;
        tag = "R5/R6";
      end
      if (deferred) tag = {tag, "/R8"};
      if (m_cfg[2:0] != 3'b111) tag = {tag, "/R10"};
    end
    #1;
    check(tag, "out_valid", out_valid, e_valid);
    check(tag, "out_data", out_data, e_data);
    check(m_cfg[7] ? "R7" : "R1", "dclk(clk high)", out_dclk, m_cfg[7] & ~m_cfg[3]);
  end

  always @(negedge clk) begin
    #1;
    if (rst_n) begin
      logic [7:0] c;
      c = (m_slot == 0) ? ctrl : m_cfg;
      check("R9", "in_ready", in_ready, c[7] && luma_slot(c, m_slot));
      check(m_cfg[7] ? "R7" : "R1", "dclk(clk low)", out_dclk, m_cfg[7] & m_cfg[3]);
    end
  end

  // watchdog
  always @(posedge clk) begin
    if (cycles > 100000) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired: actual=%0d expected<=100000 cycles", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  function automatic logic [7:0] pick_luma();
    logic [7:0] edges [12] = '{8'd0, 8'd1, 8'd2, 8'd15, 8'd16, 8'd17,
                               8'd128, 8'd234, 8'd235, 8'd236, 8'd254, 8'd255};
    if ($urandom % 3 == 0) return 8'($urandom);
    return edges[$urandom % 12];
  endfunction

  task automatic drive(input logic [7:0] c, input logic v, input logic [7:0] y);
    @(negedge clk);
    ctrl = c; in_valid = v; in_luma = y;
  endtask

  initial begin
    void'($urandom(32'h5eed));
    // R2: reset state
    repeat (3) @(negedge clk);
    check("R2", "reset out_valid", out_valid, 0);
    check("R2", "reset out_data", out_data, 0);
    check("R2", "reset dclk", out_dclk, 0);
    rst_n = 1'b1;
    // R1: output off with reset setting
    for (int i = 0; i < 6; i++) drive(8'h47, 1'b1, 8'h55);
    // R3 R4 R5 R6 R7: every setting, with gaps in input
    for (int ord = 0; ord < 4; ord++)
      for (int rng = 0; rng < 2; rng++)
        for (int ph = 0; ph < 2; ph++)
          for (int i = 0; i < 24; i++)
            drive(8'h80 | 8'(rng << 6) | 8'(ord << 4) | 8'(ph << 3) | 8'h07,
                  ($urandom % 4) != 0, pick_luma());
    // R10: fixed bits cleared or mixed
    for (int i = 0; i < 30; i++)
      drive({3'b110, 2'(i / 10), 3'(i)}, 1'b1, pick_luma());
    // R8: control changes at arbitrary cycles
    for (int i = 0; i < 400; i++)
      drive((($urandom % 5) == 0) ? 8'h47 : 8'($urandom) | 8'h80,
            ($urandom % 3) != 0, pick_luma());
    // R1: switch off mid-stream
    for (int i = 0; i < 5; i++) drive(8'hD7, 1'b1, pick_luma());
    for (int i = 0; i < 10; i++) drive(8'h47, 1'b1, pick_luma());
    @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule